// File: doc/BRIEF.md
# Packed Instruction Slot Sequencer

This block sits at the front of a stack-machine core. Each 32-bit instruction cell carries six opcode slots: five full 6-bit opcodes and a short 2-bit opcode in the low bits. The block holds the current cell in a private register and tracks which slot is executing in a private slot counter. Program code cannot reach either register. The execute stage sees one opcode at a time. It pulses `step_i` when that opcode has finished, and the sequencer then moves to the next slot.

When the last slot of a cell has been consumed, the sequencer raises a fetch request at the program address. It loads the returned cell and bumps the address by one. An opcode that uses the following slot as an inline operand asserts `skip_i` together with `step_i`. The sequencer shows that slot's value on `skip_op_o` and advances past both slots. A jump asserts `flush_i` with the target address. This drops the current cell, and fetching resumes from the target.

Top module: `slot_seq_top`

## Requirements
- R1: After reset, `fetch_req_o` is 1, `op_valid_o` is 0 and `fetch_addr_o` equals the parameter `RESET_ADDR` (default 0).
- R2: While `op_valid_o` is 1, `op_o` shows slot `slot_o` of the held cell. Slot k (0..4) is cell bits [31-6k : 26-6k], so slot 0 is bits 31:26. Slot 5 is bits 1:0, zero-extended to 6 bits.
- R3: A cell is accepted when `fetch_req_o` and `cell_valid_i` are both 1 and `flush_i` is 0. In the next cycle `op_valid_o` is 1, `fetch_req_o` is 0 and `slot_o` is 0.
- R4: `step_i` without `skip_i`, while `op_valid_o` is 1 and `slot_o` is below 5, raises `slot_o` by one in the next cycle.
- R5: `step_i` at slot 5 ends the cell. In the next cycle `fetch_req_o` is 1 and `op_valid_o` is 0, so the opcode output is invalid for as long as the fetch is outstanding.
- R6: Each accepted cell raises `fetch_addr_o` by one in the following cycle.
- R7: While `op_valid_o` is 1, `skip_op_o` shows slot `slot_o`+1, using the R2 layout, or 0 at slot 5. `step_i` with `skip_i` advances `slot_o` by two. From slot 4 it ends the cell as in R5. At slot 5 it acts as a plain step.
- R8: `flush_i` wins over every other input. In the next cycle `fetch_req_o` is 1, `op_valid_o` is 0 and `fetch_addr_o` equals the `flush_addr_i` sampled with it. A cell offered in the same cycle is dropped.
- R9: While a fetch is outstanding, `step_i` and `skip_i` have no effect and `slot_o` holds. While a cell is held, `cell_valid_i` is ignored: the opcode and address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_i | input | 32 | Instruction cell returned by memory |
| cell_valid_i | input | 1 | `cell_i` carries the requested cell |
| step_i | input | 1 | Current opcode finished |
| skip_i | input | 1 | With `step_i`: also consume the following slot as an operand |
| flush_i | input | 1 | Jump: drop the current cell and redirect fetch |
| flush_addr_i | input | 18 | Jump target address |
| fetch_req_o | output | 1 | Request for the cell at `fetch_addr_o` |
| fetch_addr_o | output | 18 | Program address of the next cell |
| op_o | output | 6 | Current opcode |
| op_valid_o | output | 1 | `op_o` and `slot_o` are meaningful |
| slot_o | output | 3 | Index of the current slot |
| skip_op_o | output | 6 | Value of the slot after the current one |

## Verification
Directed cells carry a distinct value in every slot. A wrong bit window or a missing zero-extension of the short slot therefore shows up as a wrong opcode, not a coincidental match. Skips are placed at slot 0, slot 4 and slot 5. These three cases separate a double advance, an early end of cell, and the degenerate single step. Flushes land both while a cell is held and while a fetch is outstanding with a cell arriving, which shows that redirect wins over acceptance. Random runs mix steps, skips, idle cycles, unrequested cells and jumps with random cells, so ordering faults between the counter, the address and the cell register surface against the bench's model.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  typedef enum logic {
    ST_FETCH = 1'b0,
    ST_RUN   = 1'b1
  } seq_state_e;

  function automatic int num_slots(input int cell_w, input int op_w);
    return (cell_w + op_w - 1) / op_w;
  endfunction

endpackage

// File: rtl/slot_extract.sv
module slot_extract #(
  parameter int CELL_W    = 32,
  parameter int OP_W      = 6,
  parameter int NUM_SLOTS = 6,
  parameter int IDX_W     = 4
) (
  input  logic [CELL_W-1:0] cell_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [OP_W-1:0]   op_o
);

  logic [OP_W-1:0] vals [NUM_SLOTS];

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    localparam int HI = CELL_W - 1 - k * OP_W;
    if (HI - OP_W + 1 >= 0) begin : g_full
      assign vals[k] = cell_i[HI -: OP_W];
    end else begin : g_part
      // short tail slot, zero-extended
      assign vals[k] = OP_W'(cell_i[HI:0]);
    end
  end

  always_comb begin
    op_o = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (idx_i == IDX_W'(k)) op_o = vals[k];
    end
  end

endmodule

// File: rtl/slot_ctr.sv
module slot_ctr
  import slot_seq_pkg::*;
#(
  parameter int NUM_SLOTS = 6,
  parameter int SLOT_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_valid_i,
  input  logic              step_i,
  input  logic              skip_i,
  input  logic              flush_i,
  output logic              run_o,
  output logic              load_o,
  output logic [SLOT_W-1:0] slot_o
);

  localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

  seq_state_e        state_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOT_W:0]   nxt;
  logic              wide_skip;

  assign wide_skip = skip_i && (slot_q != LAST);
  assign nxt       = {1'b0, slot_q} + (wide_skip ? (SLOT_W+1)'(2) : (SLOT_W+1)'(1));
  assign load_o    = (state_q == ST_FETCH) && cell_valid_i && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      slot_q  <= '0;
    end else if (flush_i) begin
      state_q <= ST_FETCH;
    end else if (state_q == ST_FETCH) begin
      if (cell_valid_i) begin
        state_q <= ST_RUN;
        slot_q  <= '0;
      end
    end else if (step_i) begin
      if (nxt > (SLOT_W+1)'(LAST)) state_q <= ST_FETCH;
      else                         slot_q  <= nxt[SLOT_W-1:0];
    end
  end

  assign run_o  = (state_q == ST_RUN);
  assign slot_o = slot_q;

endmodule

// File: rtl/pc_unit.sv
module pc_unit #(
  parameter int                ADDR_W     = 18,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      addr_q <= RESET_ADDR;
    else if (flush_i) addr_q <= flush_addr_i;
    else if (load_i)  addr_q <= addr_q + 1'b1;
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/slot_seq_top.sv
module slot_seq_top
  import slot_seq_pkg::*;
#(
  parameter int                CELL_W     = 32,
  parameter int                OP_W       = 6,
  parameter int                ADDR_W     = 18,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
  localparam int               NUM_SLOTS  = num_slots(CELL_W, OP_W),
  localparam int               SLOT_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CELL_W-1:0] cell_i,
  input  logic              cell_valid_i,
  input  logic              step_i,
  input  logic              skip_i,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [OP_W-1:0]   op_o,
  output logic              op_valid_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [OP_W-1:0]   skip_op_o
);

  localparam int IDX_W = SLOT_W + 1;

  logic              run;
  logic              load;
  logic [SLOT_W-1:0] slot;
  logic [CELL_W-1:0] cell_q;

  slot_ctr #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
  ) u_ctr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cell_valid_i (cell_valid_i),
    .step_i       (step_i),
    .skip_i       (skip_i),
    .flush_i      (flush_i),
    .run_o        (run),
    .load_o       (load),
    .slot_o       (slot)
  );

  pc_unit #(
    .ADDR_W     (ADDR_W),
    .RESET_ADDR (RESET_ADDR)
  ) u_pc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .flush_i      (flush_i),
    .flush_addr_i (flush_addr_i),
    .addr_o       (fetch_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cell_q <= '0;
    else if (load) cell_q <= cell_i;
  end

  slot_extract #(
    .CELL_W (CELL_W), .OP_W (OP_W), .NUM_SLOTS (NUM_SLOTS), .IDX_W (IDX_W)
  ) u_cur (
    .cell_i (cell_q),
    .idx_i  ({1'b0, slot}),
    .op_o   (op_o)
  );

  // index NUM_SLOTS is out of range and yields zero
  slot_extract #(
    .CELL_W (CELL_W), .OP_W (OP_W), .NUM_SLOTS (NUM_SLOTS), .IDX_W (IDX_W)
  ) u_nxt (
    .cell_i (cell_q),
    .idx_i  ({1'b0, slot} + IDX_W'(1)),
    .op_o   (skip_op_o)
  );

  assign op_valid_o  = run;
  assign fetch_req_o = !run;
  assign slot_o      = slot;

  // R3
  accept_starts_slot0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && cell_valid_i && !flush_i) |=> (op_valid_o && slot_o == '0));

  // R6
  accept_bumps_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && cell_valid_i && !flush_i) |=> (fetch_addr_o == $past(fetch_addr_o) + 1'b1));

  // R4
  step_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && step_i && !skip_i && !flush_i && slot_o != SLOT_W'(NUM_SLOTS-1))
    |=> (op_valid_o && slot_o == SLOT_W'($past(slot_o) + 1'b1)));

  // R5
  last_step_fetch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_o && step_i && slot_o == SLOT_W'(NUM_SLOTS-1)) |=> (fetch_req_o && !op_valid_o));

  // R8
  flush_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (fetch_req_o && fetch_addr_o == $past(flush_addr_i)));

  // R9
  fetch_wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_o && !cell_valid_i && !flush_i) |=> (fetch_req_o && $stable(slot_o) && $stable(fetch_addr_o)));

endmodule

// File: tb/slot_seq_top_tb.sv
module slot_seq_top_tb_top;

  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] cell_i = '0;
  logic        cell_valid_i = 1'b0;
  logic        step_i = 1'b0;
  logic        skip_i = 1'b0;
  logic        flush_i = 1'b0;
  logic [17:0] flush_addr_i = '0;
  logic        fetch_req_o;
  logic [17:0] fetch_addr_o;
  logic [5:0]  op_o;
  logic        op_valid_o;
  logic [2:0]  slot_o;
  logic [5:0]  skip_op_o;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  bit          m_run;
  int          m_slot;
  logic [17:0] m_addr;
  logic [31:0] m_cell;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  slot_seq_top dut_i (
    .clk_i, .rst_ni, .cell_i, .cell_valid_i, .step_i, .skip_i, .flush_i,
    .flush_addr_i, .fetch_req_o, .fetch_addr_o, .op_o, .op_valid_o,
    .slot_o, .skip_op_o
  );

  function automatic logic [5:0] slot_val(input logic [31:0] c, input int k);
    if (k < 5)  return 6'((c >> (26 - 6*k)) & 32'h3f);
    if (k == 5) return {4'b0, c[1:0]};
    return 6'd0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    chk(op_valid_o == m_run, {tag, " op_valid"}, 32'(op_valid_o), 32'(m_run));
    chk(fetch_req_o == !m_run, {tag, " fetch_req"}, 32'(fetch_req_o), 32'(!m_run));
    chk(fetch_addr_o == m_addr, {tag, " addr R6"}, 32'(fetch_addr_o), 32'(m_addr));
    if (m_run) begin
      chk(slot_o == 3'(m_slot), {tag, " slot"}, 32'(slot_o), 32'(m_slot));
      chk(op_o == slot_val(m_cell, m_slot), {tag, " op R2"}, 32'(op_o), 32'(slot_val(m_cell, m_slot)));
      chk(skip_op_o == slot_val(m_cell, m_slot + 1), {tag, " skip_op R7"},
          32'(skip_op_o), 32'(slot_val(m_cell, m_slot + 1)));
    end
  endtask

  // drive at negedge, model at posedge, compare at next negedge
  task automatic cyc(input bit st, input bit sk, input bit fl, input bit cv,
                     input logic [31:0] c, input logic [17:0] fa, input string tag);
    step_i = st; skip_i = sk; flush_i = fl; cell_valid_i = cv; cell_i = c; flush_addr_i = fa;
    @(posedge clk_i);
    if (fl) begin
      m_run = 1'b0; m_addr = fa;
    end else if (!m_run) begin
      if (cv) begin m_run = 1'b1; m_slot = 0; m_cell = c; m_addr = m_addr + 1'b1; end
    end else if (st) begin
      int n;
      n = m_slot + ((sk && m_slot != 5) ? 2 : 1);
      if (n > 5) m_run = 1'b0; else m_slot = n;
    end
    @(negedge clk_i);
    compare(tag);
  endtask

  localparam logic [31:0] C_A = {6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 2'd3};
  localparam logic [31:0] C_B = {6'h3f, 6'h2a, 6'h15, 6'h0c, 6'h33, 2'd2};

  initial begin
    void'($urandom(32'h5107_5e9a));
    m_run = 1'b0; m_slot = 0; m_addr = '0; m_cell = '0;
    #(CLK_PERIOD*2 + 1);
    // R1 reset state
    chk(fetch_req_o == 1'b1, "R1 fetch_req", 32'(fetch_req_o), 1);
    chk(op_valid_o == 1'b0, "R1 op_valid", 32'(op_valid_o), 0);
    chk(fetch_addr_o == 18'd0, "R1 addr", 32'(fetch_addr_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    compare("R1");

    // R9 step while fetching
    cyc(1, 1, 0, 0, '0, '0, "R9 step idle");
    // R3 accept
    cyc(0, 0, 0, 1, C_A, '0, "R3 accept");
    // R9 cell ignored while held
    cyc(0, 0, 0, 1, C_B, '0, "R9 cell ignored");
    // R2 R4 walk
    for (int k = 0; k < 5; k++) cyc(1, 0, 0, 0, '0, '0, "R4 walk");
    // R5 end
    cyc(1, 0, 0, 0, '0, '0, "R5 last step");
    cyc(0, 0, 0, 0, '0, '0, "R5 wait");
    // R7 skip at 0, 2, then at 4 ends
    cyc(0, 0, 0, 1, C_B, '0, "R3 accept2");
    cyc(1, 1, 0, 0, '0, '0, "R7 skip0");
    cyc(1, 1, 0, 0, '0, '0, "R7 skip2");
    cyc(1, 1, 0, 0, '0, '0, "R7 skip4 end");
    // R7 skip at 5 is plain step
    cyc(0, 0, 0, 1, C_A, '0, "R3 accept3");
    for (int k = 0; k < 5; k++) cyc(1, 0, 0, 0, '0, '0, "R4 walk2");
    cyc(1, 1, 0, 0, '0, '0, "R7 skip5");
    // R8 flush with cell offered during fetch
    cyc(0, 0, 1, 1, C_B, 18'h2abcd, "R8 flush fetch");
    cyc(0, 0, 0, 1, C_B, '0, "R8 accept after");
    cyc(1, 0, 1, 1, C_A, 18'h3ffff, "R8 flush run");
    cyc(0, 0, 0, 1, C_A, '0, "R6 wrap");

    for (int n = 0; n < 4000; n++) begin
      bit st, sk, fl, cv;
      st = ($urandom % 100) < 60;
      sk = ($urandom % 100) < 30;
      fl = ($urandom % 100) < 4;
      cv = ($urandom % 100) < 50;
      cyc(st, sk, fl, cv, $urandom, 18'($urandom), "R4 random");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog R1 act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule